// File: doc/BRIEF.md
# PWM Trip-Zone Protection Logic

This block sits between a PWM generator and the output pins. It watches two active-low fault inputs and, when a selected fault asserts, replaces the raw A and B waveforms with safe levels taken from an action field. Each fault input can be routed to a latching path or to a self-releasing path, or to both. The latching path holds the override until software clears it. The self-releasing path drops the override at the first counter-zero strobe after every selected fault input has gone back high, so a PWM period is never cut short.

Software configures the block through a small register port. It sets the source routing, the per-output actions and the interrupt enables, reads back a status word, and clears the flags by writing ones. A global interrupt flag drives the interrupt output directly.

Top module: `pwm_trip_guard`

## Requirements
- R1: Each fault input passes through two synchronizing flops. A low level sampled at clock edge k changes the outputs right after edge k+2.
- R2: The routing register at address 0 has bit i to route fault input i to the latching path and bit 2+i to route it to the self-releasing path. A fault input whose bits are both zero has no effect on the outputs or on the flags.
- R3: The action register at address 1 holds the action for A in bits [1:0] and the action for B in bits [3:2]. While an override is active, 00 drives low, 01 drives high, 10 drives low, and 11 passes the raw PWM through.
- R4: A latching trip keeps the override active after its input returns high. Writing 1 to bit 2 of the clear register (address 4) releases it. If a routed fault is still present, the trip stays set.
- R5: A self-releasing trip is set while any routed fault is present. It releases on the first counter-zero strobe that arrives after no routed fault remains.
- R6: Status bit 1 (address 3) is the self-releasing event flag. Writing 1 to clear bit 1 clears it, and it sets again at once if a routed fault persists. Status bit 2 reflects the latching trip.
- R7: The interrupt-enable register at address 2 has bit 0 for self-releasing events and bit 1 for latching events. The global flag, status bit 0, sets when an enabled status bit rises, and irq_o equals this flag.
- R8: The global flag stays set until 1 is written to clear bit 0. Events that occur while it is set raise no extra interrupt.
- R9: After reset, all registers and flags read zero, both synchronizers hold the idle-high level, and both outputs follow the raw PWM inputs.
- R10: Reads are combinational from reg_addr_i. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trip_n_i | input | 2 | Active-low fault inputs, asynchronous |
| pwm_a_i | input | 1 | Raw PWM channel A |
| pwm_b_i | input | 1 | Raw PWM channel B |
| ctr_zero_i | input | 1 | One-cycle strobe when the PWM counter is zero |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| pwm_a_o | output | 1 | Protected channel A |
| pwm_b_o | output | 1 | Protected channel B |
| irq_o | output | 1 | Interrupt, equal to the global flag |

## Verification
The assertions assume that ctr_zero_i is a single-cycle strobe that is synchronous to clk_i and that register writes last one cycle. They also assume that the fault inputs are only ever observed through the synchronizer. The stimulus drives every input on the falling edge, generates the zero strobe from a free-running period counter, and holds each fault level for several cycles. Within the stimulus, fault inputs are held long enough to be seen, cleared while still asserted, and raised again while the global flag is still set.

// File: rtl/trip_pkg.sv
package trip_pkg;

    typedef enum logic [1:0] {
        ACT_HIZ  = 2'b00,
        ACT_HI   = 2'b01,
        ACT_LO   = 2'b10,
        ACT_PASS = 2'b11
    } trip_act_e;

    localparam logic [2:0] ADDR_SEL    = 3'd0;
    localparam logic [2:0] ADDR_ACT    = 3'd1;
    localparam logic [2:0] ADDR_IEN    = 3'd2;
    localparam logic [2:0] ADDR_STATUS = 3'd3;
    localparam logic [2:0] ADDR_CLR    = 3'd4;

    localparam int CLR_INT_BIT = 0;
    localparam int CLR_CBC_BIT = 1;
    localparam int CLR_OST_BIT = 2;

    localparam int IEN_CBC_BIT = 0;
    localparam int IEN_OST_BIT = 1;

endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] trip_n_i,
    output logic [N-1:0] fault_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = trip_n_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = ~st_q.s2;

endmodule

// File: rtl/trip_state.sv
module trip_state #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] fault_i,
    input  logic [N-1:0] sel_ost_i,
    input  logic [N-1:0] sel_cbc_i,
    input  logic         zero_i,
    input  logic         clr_ost_i,
    input  logic         clr_cbc_i,
    output logic         ost_o,
    output logic         cbc_act_o,
    output logic         cbc_flag_o
);

    typedef struct packed {
        logic ost;
        logic cbc_act;
        logic cbc_flag;
    } state_t;

    state_t st_d, st_q;
    logic   hit_ost;
    logic   hit_cbc;

    always_comb begin
        hit_ost         = |(fault_i & sel_ost_i);
        hit_cbc         = |(fault_i & sel_cbc_i);
        st_d            = st_q;
        st_d.ost        = hit_ost | (st_q.ost & ~clr_ost_i);
        st_d.cbc_act    = hit_cbc | (st_q.cbc_act & ~zero_i);
        st_d.cbc_flag   = hit_cbc | (st_q.cbc_flag & ~clr_cbc_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ost_o      = st_q.ost;
    assign cbc_act_o  = st_q.cbc_act;
    assign cbc_flag_o = st_q.cbc_flag;

    // R4
    ost_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ost && !clr_ost_i) |=> st_q.ost);

    // R5
    cbc_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.cbc_act) |-> $past(zero_i));

    // R2
    cbc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_cbc |=> st_q.cbc_act);

    // R6
    cbc_flag_persist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_cbc |=> st_q.cbc_flag);

endmodule

// File: rtl/trip_override.sv
module trip_override
    import trip_pkg::*;
(
    input  logic       active_i,
    input  logic [1:0] act_i,
    input  logic       pwm_i,
    output logic       pwm_o
);

    trip_act_e act;

    always_comb begin
        act = trip_act_e'(act_i);
        if (!active_i) begin
            pwm_o = pwm_i;
        end else begin
            unique case (act)
                ACT_HI:   pwm_o = 1'b1;
                ACT_LO:   pwm_o = 1'b0;
                ACT_PASS: pwm_o = pwm_i;
                default:  pwm_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
    import trip_pkg::*;
#(
    parameter int N_TRIP = 2,
    parameter int AW     = 3,
    parameter int DW     = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_TRIP-1:0] trip_n_i,
    input  logic              pwm_a_i,
    input  logic              pwm_b_i,
    input  logic              ctr_zero_i,
    input  logic              reg_we_i,
    input  logic [AW-1:0]     reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              pwm_a_o,
    output logic              pwm_b_o,
    output logic              irq_o
);

    localparam int SEL_W = 2 * N_TRIP;
    localparam int N_CH  = 2;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [2*N_CH-1:0] act;
        logic [1:0]        ien;
        logic              int_flag;
    } regs_t;

    regs_t rg_d, rg_q;

    logic [N_TRIP-1:0] fault;
    logic              ost, cbc_act, cbc_flag;
    logic              ost_d_seen, cbc_flag_d_seen;
    logic              wr_clr, clr_int, clr_cbc, clr_ost;
    logic              trip_active;
    logic [N_CH-1:0]   pwm_in, pwm_out;

    trip_sync #(.N(N_TRIP)) u_sync (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .trip_n_i (trip_n_i),
        .fault_o  (fault)
    );

    always_comb begin
        wr_clr  = reg_we_i && (reg_addr_i == AW'(ADDR_CLR));
        clr_int = wr_clr && reg_wdata_i[CLR_INT_BIT];
        clr_cbc = wr_clr && reg_wdata_i[CLR_CBC_BIT];
        clr_ost = wr_clr && reg_wdata_i[CLR_OST_BIT];
    end

    trip_state #(.N(N_TRIP)) u_state (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fault_i    (fault),
        .sel_ost_i  (rg_q.sel[N_TRIP-1:0]),
        .sel_cbc_i  (rg_q.sel[SEL_W-1:N_TRIP]),
        .zero_i     (ctr_zero_i),
        .clr_ost_i  (clr_ost),
        .clr_cbc_i  (clr_cbc),
        .ost_o      (ost),
        .cbc_act_o  (cbc_act),
        .cbc_flag_o (cbc_flag)
    );

    // Next-cycle status values, seen from outside the state module.
    always_comb begin
        ost_d_seen      = (|(fault & rg_q.sel[N_TRIP-1:0])) | (ost & ~clr_ost);
        cbc_flag_d_seen = (|(fault & rg_q.sel[SEL_W-1:N_TRIP])) | (cbc_flag & ~clr_cbc);
    end

    always_comb begin
        rg_d = rg_q;
        if (reg_we_i) begin
            unique case (reg_addr_i)
                AW'(ADDR_SEL): rg_d.sel = reg_wdata_i[SEL_W-1:0];
                AW'(ADDR_ACT): rg_d.act = reg_wdata_i[2*N_CH-1:0];
                AW'(ADDR_IEN): rg_d.ien = reg_wdata_i[1:0];
                default:       ;
            endcase
        end
        rg_d.int_flag = (rg_q.int_flag & ~clr_int)
                      | (rg_q.ien[IEN_OST_BIT] & ost_d_seen & ~ost)
                      | (rg_q.ien[IEN_CBC_BIT] & cbc_flag_d_seen & ~cbc_flag);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            AW'(ADDR_SEL):    reg_rdata_o[SEL_W-1:0]  = rg_q.sel;
            AW'(ADDR_ACT):    reg_rdata_o[2*N_CH-1:0] = rg_q.act;
            AW'(ADDR_IEN):    reg_rdata_o[1:0]        = rg_q.ien;
            AW'(ADDR_STATUS): reg_rdata_o[2:0]        = {ost, cbc_flag, rg_q.int_flag};
            default:          reg_rdata_o             = '0;
        endcase
    end

    assign trip_active = ost | cbc_act;
    assign pwm_in      = {pwm_b_i, pwm_a_i};

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        trip_override u_ovr (
            .active_i (trip_active),
            .act_i    (rg_q.act[2*g +: 2]),
            .pwm_i    (pwm_in[g]),
            .pwm_o    (pwm_out[g])
        );
    end

    assign pwm_a_o = pwm_out[0];
    assign pwm_b_o = pwm_out[1];
    assign irq_o   = rg_q.int_flag;

    // R8
    irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !clr_int) |=> irq_o);

    // R7
    irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> (($rose(ost) && $past(rg_q.ien[IEN_OST_BIT]))
                       || ($rose(cbc_flag) && $past(rg_q.ien[IEN_CBC_BIT]))));

    // R3
    pass_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ost && !cbc_act) |-> (pwm_a_o == pwm_a_i && pwm_b_o == pwm_b_i));

endmodule

// File: tb/sim_pwm_trip_guard.sv
module sim_pwm_trip_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] trip_n = 2'b11;
    logic       pwm_a = 1'b0, pwm_b = 1'b0, zero = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = 3'd3;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       out_a, out_b, irq;

    int    checks = 0;
    int    fails  = 0;
    string phase  = "R9 reset";
    bit    done   = 0;

    always #5 clk = ~clk;

    pwm_trip_guard u0 (
        .clk_i(clk), .rst_ni(rst_n), .trip_n_i(trip_n),
        .pwm_a_i(pwm_a), .pwm_b_i(pwm_b), .ctr_zero_i(zero),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .pwm_a_o(out_a), .pwm_b_o(out_b), .irq_o(irq));

    // period counter drives raw PWM and zero strobe
    int pcnt = 0;
    always @(negedge clk) begin
        pcnt  = (pcnt + 1) % 8;
        zero  = (pcnt == 0);
        pwm_a = (pcnt >= 4);
        pwm_b = (pcnt % 3 == 1);
    end

    // behavioural reference
    logic [1:0] hist[$];
    int  m_sel, m_act, m_ien;
    bit  m_ost, m_cbc, m_cflag, m_int;

    function automatic bit act_out(int code, bit raw, bit active);
        if (!active) return raw;
        case (code)
            1: return 1'b1;
            3: return raw;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = {2'b11, 2'b11};
            m_sel = 0; m_act = 0; m_ien = 0;
            m_ost = 0; m_cbc = 0; m_cflag = 0; m_int = 0;
        end else begin
            logic [1:0] seen;
            bit c_int, c_cbc, c_ost, h_ost, h_cbc, n_ost, n_cflag;
            seen  = hist.pop_front();
            hist.push_back(trip_n);
            c_int = we && addr == 4 && wdata[0];
            c_cbc = we && addr == 4 && wdata[1];
            c_ost = we && addr == 4 && wdata[2];
            h_ost = ((~seen) & m_sel[1:0]) != 0;
            h_cbc = ((~seen) & m_sel[3:2]) != 0;
            n_ost   = h_ost || (m_ost && !c_ost);
            n_cflag = h_cbc || (m_cflag && !c_cbc);
            m_int = (m_int && !c_int) || (m_ien[1] && n_ost && !m_ost)
                                      || (m_ien[0] && n_cflag && !m_cflag);
            m_cbc = h_cbc || (m_cbc && !zero);
            m_ost = n_ost;
            m_cflag = n_cflag;
            if (we && addr == 0) m_sel = wdata[3:0];
            if (we && addr == 1) m_act = wdata[3:0];
            if (we && addr == 2) m_ien = wdata[1:0];
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", phase, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!done) begin
            bit act;
            act = m_ost || m_cbc;
            check("out_a", out_a, act_out(m_act[1:0], pwm_a, act));
            check("out_b", out_b, act_out(m_act[3:2], pwm_b, act));
            check("irq", irq, m_int);
            if (!we && addr == 3)
                check("status", rdata, {5'b0, m_ost, m_cflag, m_int});
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; addr = 3'd3; wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, int exp, string tag);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata != exp) begin
            fails++;
            $display("FAIL %s readback: got %0h expected %0h", tag, rdata, exp);
        end
        addr = 3'd3;
    endtask

    initial begin
        #20000000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(4);
        rd(3'd0, 0, "R9 sel"); rd(3'd1, 0, "R9 act"); rd(3'd5, 0, "R10 unmapped");

        phase = "R2 routing";
        wr(3'd0, 8'h01); wr(3'd1, 8'h09); wr(3'd2, 8'h02);
        rd(3'd0, 8'h01, "R2 sel"); rd(3'd1, 8'h09, "R3 act"); rd(3'd2, 8'h02, "R7 ien");
        trip_n = 2'b10; idle(6); trip_n = 2'b11; idle(4);

        phase = "R1 R4 one-shot latch";
        @(negedge clk); trip_n = 2'b10; idle(1); trip_n = 2'b11; idle(12);
        wr(3'd4, 8'h04); idle(3);
        phase = "R8 held flag";
        trip_n = 2'b10; idle(3); trip_n = 2'b11; idle(3);
        wr(3'd4, 8'h04); idle(2); wr(3'd4, 8'h01); idle(3);

        phase = "R4 clear while fault held";
        trip_n = 2'b10; idle(5); wr(3'd4, 8'h05); idle(4);
        trip_n = 2'b11; idle(3); wr(3'd4, 8'h05); idle(3);

        phase = "R5 R6 cycle-by-cycle";
        wr(3'd0, 8'h08); wr(3'd2, 8'h01); wr(3'd1, 8'h06);
        trip_n = 2'b01; idle(10); trip_n = 2'b11; idle(20);
        phase = "R6 clear with fault present";
        trip_n = 2'b01; idle(4); wr(3'd4, 8'h03); idle(4);
        trip_n = 2'b11; idle(12); wr(3'd4, 8'h03); idle(3);
        phase = "R7 disabled interrupt";
        wr(3'd2, 8'h00); trip_n = 2'b01; idle(5); trip_n = 2'b11; idle(16);
        wr(3'd4, 8'h02); idle(2);
        phase = "R5 both inputs";
        wr(3'd0, 8'h0C); wr(3'd2, 8'h01);
        trip_n = 2'b00; idle(4); trip_n = 2'b10; idle(10); trip_n = 2'b11; idle(18);
        wr(3'd4, 8'h07); idle(2);

        phase = "R3 action codes";
        wr(3'd0, 8'h01);
        for (int c = 0; c < 16; c++) begin
            wr(3'd1, 8'(c));
            trip_n = 2'b10; idle(2); trip_n = 2'b11; idle(8);
            wr(3'd4, 8'h07); idle(3);
        end

        idle(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule